// File: doc/BRIEF.md
# Bus Packet Error Code Unit

This block sits beside the byte engine of a two-wire serial bus controller. It keeps a running CRC-8 over every bit that crosses the bus: the address byte, the read/write bit and each data byte. The controller shows it one bit at a time on a valid/value pair, and it also reports its own events: start or repeated start, stop, lost arbitration, and its role and data direction.

Software, or the end-of-transfer signal of a DMA channel, tells the block when the last data byte of a message has gone by. A DMA end-of-transfer arms the block only if the DMA's last-transfer flag is set with it. When the controller is transmitting, the block then offers the code byte so that it goes out right after the last byte. When the controller is receiving, the block treats the next byte as the code. It checks that byte, gives the ACK/NACK answer for it and keeps a sticky error flag, which can raise an interrupt. If arbitration is lost, the running code can no longer be trusted. The block marks it corrupted, and from then on it raises no error and answers NACK to the code byte.

Top module: `pec_unit`

## Requirements
- R1: `pec_byte` holds the CRC-8 (polynomial x^8+x^2+x+1, that is 0x07, initial value 0x00, not reflected, most significant bit first) of every bit presented with `bit_vld` high since the last start, stop or reset. It is updated on the clock edge that samples the bit.
- R2: A cycle with `ev_start` or `ev_stop` high resets the code to 0x00, the bit position within the byte, any pending final-byte arming and the corrupted mark.
- R3: While `pec_en` is low, presented bits leave the code unchanged.
- R4: A cycle with `pec_req` high, or with `dma_eot` and `dma_last` both high, arms the block for the next byte. `dma_eot` with `dma_last` low has no effect.
- R5: `pec_send` is high while the block is armed and `is_tx` is high. It drops on the first bit of the next byte, and that byte is then the code byte.
- R6: When the armed byte is received (`is_tx` low) as slave with `pec_en` high and no corruption, the answer is ACK (`ack_out`=1) if the CRC over all bits, including the received code byte, is zero, and NACK (`ack_out`=0) otherwise.
- R7: As master receiver, the armed final byte is always answered with NACK, whether or not the check passed.
- R8: Every received byte produces a one-cycle `ack_vld` pulse in the cycle after its 8th bit is sampled. Bytes that are not armed get ACK, and a slave with `pec_en` low ACKs the armed byte.
- R9: A failed check sets `pec_err`. The flag stays set across start and stop and clears only on `err_clr` or reset. A set in the same cycle as a clear wins.
- R10: `irq` equals `pec_err` AND `irq_en`.
- R11: `ev_arb_lost` sets `crc_bad` from the next cycle on and freezes the code. While `crc_bad` is high, the armed received byte sets no error and is answered with NACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pec_en | input | 1 | Enables code calculation and checking |
| irq_en | input | 1 | Interrupt enable for the error flag |
| is_master | input | 1 | Controller acts as bus master |
| is_tx | input | 1 | Controller transmits the data bytes |
| bit_vld | input | 1 | A bus bit is presented this cycle |
| bit_val | input | 1 | Value of the presented bit |
| ev_start | input | 1 | Start or repeated start seen |
| ev_stop | input | 1 | Stop seen |
| ev_arb_lost | input | 1 | Arbitration lost |
| pec_req | input | 1 | Software marks the next byte as the code byte |
| dma_eot | input | 1 | DMA end-of-transfer |
| dma_last | input | 1 | This DMA transfer is the final one |
| err_clr | input | 1 | Clears the error flag |
| pec_byte | output | 8 | Running code, to be sent as the code byte |
| pec_send | output | 1 | Next transmitted byte must be the code |
| ack_vld | output | 1 | ACK decision valid for the byte just received |
| ack_out | output | 1 | 1 = ACK, 0 = NACK |
| pec_err | output | 1 | Sticky code-mismatch flag |
| irq | output | 1 | Error interrupt |
| crc_bad | output | 1 | Code corrupted by arbitration loss |

## Verification
The hardest case to reach is an armed code byte that arrives after arbitration was lost. In that case the compare must be dropped and neither the ACK rule nor the error rule may apply. The stimulus loses arbitration partway through a message, arms the block, and sends a code byte that would fail the check. Another case that takes care to reach is a slave that ACKs a correct code byte while a master receiver NACKs the same byte. To reach it, the stimulus replays identical messages under both roles, and it builds the correct code byte from the bench's own division model.

// File: rtl/pec_pkg.sv
package pec_pkg;
  parameter int CRC_W = 8;

  // One serial CRC step, most significant bit first.
  function automatic logic [CRC_W-1:0] crc_step(
    input logic [CRC_W-1:0] cur,
    input logic             din,
    input logic [CRC_W-1:0] poly
  );
    logic fb;
    fb = cur[CRC_W-1] ^ din;
    return {cur[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
  endfunction

  // Decision for a received byte: 1 = ACK, 0 = NACK.
  function automatic logic ack_rule(
    input logic is_code,
    input logic master,
    input logic en,
    input logic bad,
    input logic match
  );
    if (!is_code) return 1'b1;
    if (master)   return 1'b0;
    if (!en)      return 1'b1;
    if (bad)      return 1'b0;
    return match;
  endfunction
endpackage

// File: rtl/pec_crc.sv
module pec_crc #(
  parameter int          W    = pec_pkg::CRC_W,
  parameter logic [W-1:0] POLY = 8'h07
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         arb_lost,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] crc,
  output logic [W-1:0] crc_nxt,
  output logic         corrupt
);
  assign crc_nxt = pec_pkg::crc_step(crc, din, POLY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc     <= '0;
      corrupt <= 1'b0;
    end else if (clr) begin
      crc     <= '0;
      corrupt <= 1'b0;
    end else begin
      if (arb_lost) corrupt <= 1'b1;
      if (shift_en && !corrupt) crc <= crc_nxt;
    end
  end
endmodule

// File: rtl/pec_frame.sv
module pec_frame #(
  parameter int BYTE_BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bit_vld,
  input  logic trigger,
  output logic first_bit,
  output logic byte_end,
  output logic armed,
  output logic code_cur
);
  localparam int CW = (BYTE_BITS > 1) ? $clog2(BYTE_BITS) : 1;
  localparam logic [CW-1:0] LAST = CW'(BYTE_BITS - 1);

  logic [CW-1:0] cnt;

  assign first_bit = bit_vld && (cnt == '0);
  assign byte_end  = bit_vld && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt      <= '0;
      armed    <= 1'b0;
      code_cur <= 1'b0;
    end else begin
      if (bit_vld) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      if (first_bit) code_cur <= armed;
      if (trigger) armed <= 1'b1;
      else if (first_bit) armed <= 1'b0;
    end
  end
endmodule

// File: rtl/pec_resp.sv
module pec_resp (
  input  logic clk,
  input  logic rst_n,
  input  logic byte_end,
  input  logic code_cur,
  input  logic is_tx,
  input  logic is_master,
  input  logic pec_en,
  input  logic corrupt,
  input  logic match,
  input  logic err_clr,
  output logic chk_fail,
  output logic ack_vld,
  output logic ack_out,
  output logic pec_err
);
  assign chk_fail = byte_end && code_cur && !is_tx && pec_en && !corrupt && !match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_vld <= 1'b0;
      ack_out <= 1'b0;
      pec_err <= 1'b0;
    end else begin
      ack_vld <= byte_end && !is_tx;
      if (byte_end && !is_tx)
        ack_out <= pec_pkg::ack_rule(code_cur, is_master, pec_en, corrupt, match);
      if (chk_fail)     pec_err <= 1'b1;
      else if (err_clr) pec_err <= 1'b0;
    end
  end
endmodule

// File: rtl/pec_unit.sv
module pec_unit #(
  parameter int          CRC_W     = pec_pkg::CRC_W,
  parameter logic [7:0]  POLY      = 8'h07,
  parameter int          BYTE_BITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pec_en,
  input  logic             irq_en,
  input  logic             is_master,
  input  logic             is_tx,
  input  logic             bit_vld,
  input  logic             bit_val,
  input  logic             ev_start,
  input  logic             ev_stop,
  input  logic             ev_arb_lost,
  input  logic             pec_req,
  input  logic             dma_eot,
  input  logic             dma_last,
  input  logic             err_clr,
  output logic [CRC_W-1:0] pec_byte,
  output logic             pec_send,
  output logic             ack_vld,
  output logic             ack_out,
  output logic             pec_err,
  output logic             irq,
  output logic             crc_bad
);
  // Named internal events, visible to the bound checker.
  logic             frame_clr;
  logic             trigger;
  logic             first_bit;
  logic             byte_end;
  logic             armed;
  logic             code_cur;
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_nxt;
  logic             match;
  logic             chk_fail;

  assign frame_clr = ev_start || ev_stop;
  assign trigger   = pec_req || (dma_eot && dma_last);
  assign match     = (crc_nxt == '0);

  pec_crc #(.W(CRC_W), .POLY(POLY[CRC_W-1:0])) u_crc (
    .clk(clk), .rst_n(rst_n), .clr(frame_clr), .arb_lost(ev_arb_lost),
    .shift_en(bit_vld && pec_en), .din(bit_val),
    .crc(crc_q), .crc_nxt(crc_nxt), .corrupt(crc_bad)
  );

  pec_frame #(.BYTE_BITS(BYTE_BITS)) u_frame (
    .clk(clk), .rst_n(rst_n), .clr(frame_clr), .bit_vld(bit_vld),
    .trigger(trigger), .first_bit(first_bit), .byte_end(byte_end),
    .armed(armed), .code_cur(code_cur)
  );

  pec_resp u_resp (
    .clk(clk), .rst_n(rst_n), .byte_end(byte_end), .code_cur(code_cur),
    .is_tx(is_tx), .is_master(is_master), .pec_en(pec_en),
    .corrupt(crc_bad), .match(match), .err_clr(err_clr),
    .chk_fail(chk_fail), .ack_vld(ack_vld), .ack_out(ack_out),
    .pec_err(pec_err)
  );

  assign pec_byte = crc_q;
  assign pec_send = armed && is_tx;
  assign irq      = pec_err && irq_en;
endmodule

// File: rtl/pec_unit_chk.sv
module pec_unit_chk #(
  parameter int CRC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pec_en,
  input logic             is_master,
  input logic             is_tx,
  input logic             ev_start,
  input logic             ev_stop,
  input logic             ev_arb_lost,
  input logic             err_clr,
  input logic             byte_end,
  input logic             code_cur,
  input logic [CRC_W-1:0] crc_q,
  input logic             pec_send,
  input logic             ack_vld,
  input logic             ack_out,
  input logic             pec_err,
  input logic             irq,
  input logic             crc_bad
);
  // R2
  crc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_start || ev_stop) |=> (crc_q == '0));
  // R3
  crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pec_en && !ev_start && !ev_stop) |=> $stable(crc_q));
  // R5
  send_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pec_send |-> is_tx);
  // R7
  master_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_end && code_cur && !is_tx && is_master) |=> (ack_vld && !ack_out));
  // R8
  ack_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vld |-> $past(byte_end && !is_tx));
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pec_err && !err_clr) |=> pec_err);
  // R10
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> pec_err);
  // R11
  arb_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_arb_lost && !ev_start && !ev_stop) |=> crc_bad);
endmodule

bind pec_unit pec_unit_chk #(.CRC_W(CRC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pec_en(pec_en), .is_master(is_master),
  .is_tx(is_tx), .ev_start(ev_start), .ev_stop(ev_stop),
  .ev_arb_lost(ev_arb_lost), .err_clr(err_clr), .byte_end(byte_end),
  .code_cur(code_cur), .crc_q(crc_q), .pec_send(pec_send),
  .ack_vld(ack_vld), .ack_out(ack_out), .pec_err(pec_err), .irq(irq),
  .crc_bad(crc_bad)
);

// File: tb/pec_unit_test.sv
module pec_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pec_en = 1'b0, irq_en = 1'b0, is_master = 1'b0, is_tx = 1'b0;
  logic bit_vld = 1'b0, bit_val = 1'b0;
  logic ev_start = 1'b0, ev_stop = 1'b0, ev_arb_lost = 1'b0;
  logic pec_req = 1'b0, dma_eot = 1'b0, dma_last = 1'b0, err_clr = 1'b0;
  logic [7:0] pec_byte;
  logic pec_send, ack_vld, ack_out, pec_err, irq, crc_bad;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pec_unit uut (
    .clk(clk), .rst_n(rst_n), .pec_en(pec_en), .irq_en(irq_en),
    .is_master(is_master), .is_tx(is_tx), .bit_vld(bit_vld),
    .bit_val(bit_val), .ev_start(ev_start), .ev_stop(ev_stop),
    .ev_arb_lost(ev_arb_lost), .pec_req(pec_req), .dma_eot(dma_eot),
    .dma_last(dma_last), .err_clr(err_clr), .pec_byte(pec_byte),
    .pec_send(pec_send), .ack_vld(ack_vld), .ack_out(ack_out),
    .pec_err(pec_err), .irq(irq), .crc_bad(crc_bad)
  );

  // Reference model: polynomial long division over the stored bit stream.
  bit m_q[$];
  int m_cnt = 0;
  bit m_armed = 0, m_code = 0, m_bad = 0, m_err = 0, m_av = 0, m_ao = 0;

  function automatic int crc_div(bit q[$]);
    int r = 0;
    foreach (q[i]) begin
      r = (r << 1) | int'(q[i]);
      if (r & 256) r = r ^ 263;
    end
    for (int k = 0; k < 8; k++) begin
      r = r << 1;
      if (r & 256) r = r ^ 263;
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_q.delete(); m_cnt = 0; m_armed = 0; m_code = 0;
      m_bad = 0; m_err = 0; m_av = 0; m_ao = 0;
    end else begin
      bit clr_e, trg, first, last, fail_now;
      bit nq[$];
      nq = m_q;
      clr_e = ev_start || ev_stop;
      trg   = pec_req || (dma_eot && dma_last);
      first = bit_vld && m_cnt == 0;
      last  = bit_vld && m_cnt == 7;
      if (bit_vld && pec_en && !m_bad) nq.push_back(bit_val);
      fail_now = last && m_code && !is_tx && pec_en && !m_bad && crc_div(nq) != 0;
      m_av = last && !is_tx;
      if (last && !is_tx) begin
        if (!m_code) m_ao = 1;
        else if (is_master) m_ao = 0;
        else if (!pec_en) m_ao = 1;
        else if (m_bad) m_ao = 0;
        else m_ao = (crc_div(nq) == 0);
      end
      if (fail_now) m_err = 1;
      else if (err_clr) m_err = 0;
      if (clr_e) begin
        m_q.delete(); m_cnt = 0; m_armed = 0; m_code = 0; m_bad = 0;
      end else begin
        if (ev_arb_lost) m_bad = 1;
        m_q = nq;
        if (bit_vld) m_cnt = (m_cnt + 1) % 8;
        if (first) m_code = m_armed;
        if (trg) m_armed = 1;
        else if (first) m_armed = 0;
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the clock edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 code value", pec_byte, crc_div(m_q));
      chk("R5 send request", pec_send, m_armed && is_tx);
      chk("R8 ack strobe", ack_vld, m_av);
      if (m_av) chk("R6/R7 ack decision", ack_out, m_ao);
      chk("R9 error flag", pec_err, m_err);
      chk("R10 interrupt", irq, m_err && irq_en);
      chk("R11 corrupted mark", crc_bad, m_bad);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<50000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk); #2;
    bit_vld = 0; ev_start = 0; ev_stop = 0; ev_arb_lost = 0;
    pec_req = 0; dma_eot = 0; dma_last = 0; err_clr = 0;
  endtask

  task automatic send_byte(logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      bit_vld = 1; bit_val = b[i]; tick();
    end
    tick(); tick();
  endtask

  task automatic start_msg(); ev_start = 1; tick(); endtask
  task automatic stop_msg();  ev_stop = 1;  tick(); endtask
  task automatic arm();       pec_req = 1;  tick(); endtask

  task automatic rx_msg(logic bad_code);
    logic [7:0] code;
    start_msg();
    send_byte(8'hA5); send_byte(8'h3C); send_byte(8'h01);
    arm();
    code = 8'(crc_div(m_q));
    send_byte(bad_code ? code ^ 8'h10 : code);
    stop_msg();
  endtask

  initial begin
    repeat (3) tick();
    @(negedge clk);
    // Reset state (R2, R9)
    chk("R2 reset code", pec_byte, 0);
    chk("R9 reset flag", pec_err, 0);
    chk("R8 reset strobe", ack_vld, 0);
    rst_n = 1; pec_en = 1; tick();

    // R1/R6: slave receive, correct code byte -> ACK
    is_master = 0; is_tx = 0; rx_msg(0);
    chk("R6 no error after good code", pec_err, 0);
    // R6/R9/R10: wrong code byte -> NACK, sticky flag, interrupt
    irq_en = 1; rx_msg(1);
    chk("R9 flag set on mismatch", pec_err, 1);
    chk("R10 irq with enable", irq, 1);
    start_msg(); send_byte(8'h11); stop_msg();
    chk("R9 flag survives start/stop", pec_err, 1);
    err_clr = 1; tick();
    chk("R9 flag cleared", pec_err, 0);
    // R7: master receiver NACKs a correct code byte
    is_master = 1; rx_msg(0);
    chk("R7 good code gives no error", pec_err, 0);

    // R4/R5: transmit, DMA end without last-transfer does nothing
    is_tx = 1;
    start_msg(); send_byte(8'h5A); send_byte(8'hC3);
    dma_eot = 1; dma_last = 0; tick();
    chk("R4 non-final DMA end ignored", pec_send, 0);
    send_byte(8'h77);
    dma_eot = 1; dma_last = 1; tick();
    chk("R4 final DMA end arms", pec_send, 1);
    chk("R1 code offered", pec_byte, crc_div(m_q));
    send_byte(pec_byte);
    chk("R5 send request drops", pec_send, 0);
    chk("R1 residue zero after code", pec_byte, 0);
    stop_msg();
    chk("R2 clear on stop", pec_byte, 0);

    // R3: calculation off
    start_msg(); send_byte(8'h9E);
    pec_en = 0; send_byte(8'hFF); send_byte(8'h00);
    chk("R3 code frozen", pec_byte, crc_div(m_q));
    pec_en = 1; stop_msg();

    // R11: arbitration loss, failing code byte as slave -> no error, NACK
    is_tx = 0; is_master = 0;
    start_msg(); send_byte(8'hB4);
    ev_arb_lost = 1; tick();
    chk("R11 marked corrupt", crc_bad, 1);
    send_byte(8'h42); arm();
    send_byte(8'h00);
    chk("R11 no error when corrupt", pec_err, 0);
    start_msg();
    chk("R11 mark cleared by start", crc_bad, 0);
    stop_msg();

    // R8: slave with calc off ACKs armed byte; master with calc off NACKs
    pec_en = 0;
    start_msg(); send_byte(8'h12);
    dma_eot = 1; dma_last = 1; tick();
    send_byte(8'h34); stop_msg();
    is_master = 1;
    start_msg(); send_byte(8'h12); arm(); send_byte(8'h34); stop_msg();
    pec_en = 1;
    chk("R8 error untouched when off", pec_err, 0);

    repeat (3) tick();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule